// File: doc/BRIEF.md
# 8-bit Timer / Event Counter with Overflow Flag and Interrupt

This block holds one 8-bit count register that a small core runs in one of two ways. In timer mode the register advances once every 32 pulses of an internal tick enable, and a 5-bit prescaler supplies that division. In event mode it advances on each high-to-low transition of an external input, after that input has been synchronised to the clock. Instruction decoding has already been reduced to one-cycle command strobes: start as timer, start as event counter, stop, load, test the flag, and enable or disable the interrupt.

The core reads the register through `count_o` at any time and loads it with `load_i`/`load_data_i`. When the count wraps from FFh to 00h, an overflow flag is set. If the interrupt is enabled, a request is also latched and held until it is acknowledged. Testing the flag reports its value on `flag_o`, and the same strobe clears the flag. Interrupt priority and vectoring are handled elsewhere.

Top module: `tcnt_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released: `count_o` = 00h, `flag_o` = 0, `irq_o` = 0, the mode is stopped and the interrupt is disabled.
- R2: In timer mode the count advances by one on every 32nd cycle in which `tick_i` is high. `start_tmr_i` clears the prescaler, so the first increment lands on the 32nd tick after the start.
- R3: In event mode the count advances once for each high-to-low transition of `evt_i`. The new value appears at `count_o` after the third rising clock edge that follows the change of `evt_i`. Low-to-high transitions and `tick_i` have no effect in this mode.
- R4: After `stop_i` the register holds its value, whatever `tick_i` and `evt_i` do.
- R5: `load_i` writes `load_data_i` into the register at the next edge. A load wins over an increment in the same cycle, and that suppressed increment causes no overflow.
- R6: An increment from FFh to 00h sets `flag_o` at the same edge.
- R7: `test_flag_i` clears the flag at the next edge. An overflow in the same cycle wins, and the flag stays set.
- R8: An overflow while the interrupt is enabled (`irq_en_i`, cleared by `irq_dis_i`) sets `irq_o`. `irq_o` holds until `irq_ack_i`. An overflow while the interrupt is disabled leaves `irq_o` low.
- R9: When command strobes coincide, `stop_i` beats `start_tmr_i`, and `start_tmr_i` beats `start_cnt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal tick enable feeding the prescaler |
| evt_i | input | 1 | External event input, asynchronous |
| start_tmr_i | input | 1 | Start in timer mode |
| start_cnt_i | input | 1 | Start in event-counter mode |
| stop_i | input | 1 | Halt counting |
| load_i | input | 1 | Load register from accumulator |
| load_data_i | input | 8 | Load value |
| test_flag_i | input | 1 | Test-and-clear of the overflow flag |
| irq_en_i | input | 1 | Enable overflow interrupt |
| irq_dis_i | input | 1 | Disable overflow interrupt |
| irq_ack_i | input | 1 | Acknowledge pending interrupt |
| count_o | output | 8 | Current register value |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Pending overflow interrupt |

## Verification
A wrong count value or a wrong mode shows on `count_o` within one edge of the next load or increment. A prescaler phase error stays hidden until the next increment and then shifts it by up to 31 ticks, so the vectors use tick totals that are both just short of and exact multiples of 32. A lost or doubled synchronised edge shows up three cycles after the input falls. A corrupted flag or interrupt state shows immediately on `flag_o` or `irq_o`. The coincidence cases (load against increment, test against overflow, stacked commands) are driven in the exact cycle where they collide.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_TIMER = 2'd1,
    M_EVENT = 2'd2
  } tmode_e;
endpackage

// File: rtl/tcnt_edge_sync.sv
module tcnt_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], async_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_N-1];
endmodule

// File: rtl/tcnt_prescale.sv
module tcnt_prescale #(
  parameter int PRE_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic step_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i)             pre_q <= '0;
    else if (run_i && tick_i)   pre_q <= pre_q + 1'b1;
  end

  assign step_o = run_i & tick_i & ~clr_i & (&pre_q);

  p_pre_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
endmodule

// File: rtl/tcnt_counter.sv
module tcnt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_data_i;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign ovf_o   = step_i & ~load_i & (&cnt_q);

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_data_i)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tcnt_irq.sv
module tcnt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic test_i,
  input  logic en_i,
  input  logic dis_i,
  input  logic ack_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, en_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // a fresh overflow outranks the test-and-clear
      if (ovf_i)       flag_q <= 1'b1;
      else if (test_i) flag_q <= 1'b0;
      if (dis_i)       en_q <= 1'b0;
      else if (en_i)   en_q <= 1'b1;
      if (ovf_i && en_q) irq_q <= 1'b1;
      else if (ack_i)    irq_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  p_flag_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag_q);
  p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && !ovf_i) |=> !flag_q);
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);
  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !irq_q) |=> !irq_q);
endmodule

// File: rtl/tcnt_unit.sv
module tcnt_unit
  import tcnt_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PRE_W  = 5,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             evt_i,
  input  logic             start_tmr_i,
  input  logic             start_cnt_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             test_flag_i,
  input  logic             irq_en_i,
  input  logic             irq_dis_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o
);
  tmode_e mode_q;
  logic   tmr_step, evt_fall, step, ovf, pre_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= M_IDLE;
    else if (stop_i)      mode_q <= M_IDLE;
    else if (start_tmr_i) mode_q <= M_TIMER;
    else if (start_cnt_i) mode_q <= M_EVENT;
  end

  assign pre_clr = start_tmr_i & ~stop_i;

  tcnt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr),
    .run_i  (mode_q == M_TIMER),
    .tick_i (tick_i),
    .step_o (tmr_step)
  );

  tcnt_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (evt_i),
    .fall_o  (evt_fall)
  );

  assign step = tmr_step | ((mode_q == M_EVENT) & evt_fall);

  tcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .count_o     (count_o),
    .ovf_o       (ovf)
  );

  tcnt_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovf_i  (ovf),
    .test_i (test_flag_i),
    .en_i   (irq_en_i),
    .dis_i  (irq_dis_i),
    .ack_i  (irq_ack_i),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (mode_q == M_IDLE));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_IDLE && !load_i) |=> $stable(count_o));
endmodule

// File: tb/tcnt_unit_test.sv
module tcnt_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 0, evt_i = 0, start_tmr_i = 0, start_cnt_i = 0, stop_i = 0;
  logic       load_i = 0, test_flag_i = 0, irq_en_i = 0, irq_dis_i = 0, irq_ack_i = 0;
  logic [7:0] load_data_i = '0;
  logic [7:0] count_o;
  logic       flag_o, irq_o;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcnt_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .evt_i(evt_i),
    .start_tmr_i(start_tmr_i), .start_cnt_i(start_cnt_i), .stop_i(stop_i),
    .load_i(load_i), .load_data_i(load_data_i), .test_flag_i(test_flag_i),
    .irq_en_i(irq_en_i), .irq_dis_i(irq_dis_i), .irq_ack_i(irq_ack_i),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // {load value, timer ticks, expected count, expected flag}
  localparam logic [24:0] VEC [8] = '{
    {8'h10, 8'd32,  8'h11, 1'b0},
    {8'hFF, 8'd32,  8'h00, 1'b1},
    {8'hFE, 8'd64,  8'h00, 1'b1},
    {8'h05, 8'd31,  8'h05, 1'b0},
    {8'hFF, 8'd31,  8'hFF, 1'b0},
    {8'h7F, 8'd96,  8'h82, 1'b0},
    {8'hF0, 8'd255, 8'hF7, 1'b0},
    {8'hFA, 8'd200, 8'h00, 1'b1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v);
    load_i = 1; load_data_i = v; cyc(1); load_i = 0;
  endtask

  task automatic do_start_tmr();
    start_tmr_i = 1; cyc(1); start_tmr_i = 0;
  endtask

  task automatic do_stop();
    stop_i = 1; cyc(1); stop_i = 0;
  endtask

  task automatic do_ticks(input int n);
    tick_i = 1; cyc(n); tick_i = 0;
  endtask

  initial begin
    cyc(2);
    chk("R1 count in reset", count_o, 8'h00);
    chk("R1 flag in reset", {7'b0, flag_o}, 8'h00);
    chk("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    cyc(1);
    // R1: stopped after reset, ticks have no effect
    do_ticks(40);
    chk("R1 idle after reset", count_o, 8'h00);

    // R2 R6 R7 table: load, run timer, stop, check, test-and-clear
    foreach (VEC[i]) begin
      do_load(VEC[i][24:17]);
      do_start_tmr();
      do_ticks(int'(VEC[i][16:9]));
      do_stop();
      chk($sformatf("R2 vec%0d count", i), count_o, VEC[i][8:1]);
      chk($sformatf("R6 vec%0d flag", i), {7'b0, flag_o}, {7'b0, VEC[i][0]});
      chk($sformatf("R8 vec%0d irq disabled", i), {7'b0, irq_o}, 8'h00);
      test_flag_i = 1; cyc(1); test_flag_i = 0;
      chk($sformatf("R7 vec%0d flag cleared", i), {7'b0, flag_o}, 8'h00);
    end

    // R9: timer start beats event start
    do_load(8'h00);
    start_tmr_i = 1; start_cnt_i = 1; cyc(1); start_tmr_i = 0; start_cnt_i = 0;
    do_ticks(32);
    chk("R9 timer over event", count_o, 8'h01);
    // R9: stop beats start
    stop_i = 1; start_tmr_i = 1; cyc(1); stop_i = 0; start_tmr_i = 0;
    do_ticks(40);
    chk("R9 stop over start", count_o, 8'h01);

    // R3 event mode
    evt_i = 1; cyc(4);
    do_load(8'h00);
    start_cnt_i = 1; cyc(1); start_cnt_i = 0;
    evt_i = 0;
    cyc(2);
    chk("R3 before third edge", count_o, 8'h00);
    cyc(1);
    chk("R3 after third edge", count_o, 8'h01);
    evt_i = 1;
    do_ticks(40);
    chk("R3 rising edge and ticks ignored", count_o, 8'h01);
    evt_i = 0; cyc(4); evt_i = 1; cyc(4);
    chk("R3 second falling edge", count_o, 8'h02);
    // R4 stop in event mode
    do_stop();
    evt_i = 0; cyc(5); evt_i = 1; cyc(5);
    chk("R4 stopped event mode holds", count_o, 8'h02);

    // R5: load beats increment, no overflow
    do_load(8'hFF);
    do_start_tmr();
    do_ticks(31);
    tick_i = 1; load_i = 1; load_data_i = 8'h40; cyc(1);
    tick_i = 0; load_i = 0;
    chk("R5 load over increment", count_o, 8'h40);
    chk("R5 no overflow", {7'b0, flag_o}, 8'h00);
    do_stop();

    // R7: overflow beats test in same cycle
    do_load(8'hFF);
    do_start_tmr();
    do_ticks(31);
    tick_i = 1; test_flag_i = 1; cyc(1);
    tick_i = 0; test_flag_i = 0;
    chk("R7 overflow over clear", {7'b0, flag_o}, 8'h01);
    chk("R6 wrap to zero", count_o, 8'h00);
    test_flag_i = 1; cyc(1); test_flag_i = 0;
    chk("R7 test clears", {7'b0, flag_o}, 8'h00);
    do_stop();

    // R8 interrupt enabled, held until ack
    irq_en_i = 1; cyc(1); irq_en_i = 0;
    do_load(8'hFF);
    do_start_tmr();
    do_ticks(32);
    chk("R8 irq raised", {7'b0, irq_o}, 8'h01);
    cyc(5);
    chk("R8 irq held", {7'b0, irq_o}, 8'h01);
    irq_ack_i = 1; cyc(1); irq_ack_i = 0;
    chk("R8 irq acked", {7'b0, irq_o}, 8'h00);
    // R8 disabled: flag but no irq
    irq_dis_i = 1; cyc(1); irq_dis_i = 0;
    do_load(8'hFF);
    do_ticks(32);
    chk("R8 flag while disabled", {7'b0, flag_o}, 8'h01);
    chk("R8 no irq while disabled", {7'b0, irq_o}, 8'h00);
    do_stop();

    // R4 timer stopped holds
    do_ticks(64);
    chk("R4 stopped timer holds", count_o, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule